// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point operands (1 sign bit, 8-bit exponent with bias 127, 23-bit fraction with an implied leading one). Each cycle it can accept a new operand pair, marked by a valid strobe. The product appears a fixed three cycles later, marked by its own valid bit. Two status flags come with the product. One shows that the result was too large and was replaced by infinity. The other shows that it was too small and was replaced by zero.

The datapath is split into three registered stages. The first stage classifies the operands, forms the result sign, and adds the biased exponents, subtracting the bias once. The second stage multiplies the two 24-bit significands. The third stage applies one optional normalizing right shift, tests for underflow, rounds to nearest with ties to even, and renormalizes if the rounding carries out. It then tests for overflow and selects the special-value encodings. Operands whose exponent field is zero are treated as zeros: subnormals are flushed and never produced.

Top module: `spm_fmul_pipe`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly three rising clock edges, with one result for each accepted pair, in order and back to back.
- R2: For two normal operands, the sign bit 31 is the XOR of the operand sign bits. The biased exponent (bits 30:23) is ea + eb − 127, plus one when the significand product is 2 or more. The fraction (bits 22:0) is the significand product after at most one right shift.
- R3: The result is rounded to nearest with ties to even. The guard bit and round bit are the two product bits just below the kept 24 bits, and the sticky bit is the OR of all lower bits. The block rounds up when guard is 1 and at least one of round, sticky or the kept LSB is 1.
- R4: When rounding carries out of the 24-bit significand, the fraction becomes zero and the exponent is incremented by one.
- R5: When the biased exponent after rounding exceeds 254, the result is a signed infinity (exponent 255, fraction 0) and `out_ovf` is 1.
- R6: When the biased exponent after normalization and before rounding is below 1, the result is a signed zero and `out_unf` is 1.
- R7: An operand with exponent field 0 is taken as zero, whatever its fraction. Its product with a finite value is a zero with sign XOR, and both flags stay low.
- R8: If any operand is a NaN (exponent 255, nonzero fraction), or the operands are an infinity and a zero, the result is 0x7FC00000 and both flags stay low.
- R9: An infinity times a nonzero non-NaN value gives an infinity with sign XOR, and both flags stay low.
- R10: While `rst_n` is low, and afterwards whenever `out_valid` is low, `out_ovf` and `out_unf` are 0. During reset, `out_prod` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair valid |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Product valid, three cycles after `in_valid` |
| out_prod | output | 32 | Product |
| out_ovf | output | 1 | Result replaced by infinity because it was too large |
| out_unf | output | 1 | Result replaced by zero because it was too small |

## Verification
The directed cases target several corner cases:
- Exact ties with odd and with even LSBs: a design that ignored the sticky bit or the LSB would round the even tie up.
- A significand product of 2^47 − 2 that rounds up across the 24-bit boundary: a design with no renormalization would output a zero fraction at the old exponent, or wrap the fraction.
- Overflow reached only through that carry, and underflow one step below the smallest normal: misplaced overflow or underflow checks would let a wrapped exponent field through.
- Subnormal operands meeting infinity, which must give the quiet NaN rather than infinity.

Random pairs with the exponent kept mostly near the bias, mixed with fully random bit patterns, fill the normal path and the random NaN and infinity encodings. The bench streams these pairs back to back and with gaps, so a latency error or a lost valid bit shows up as a misplaced or missing result.

// File: rtl/spm_pkg.sv
package spm_pkg;
    localparam int EW   = 8;
    localparam int FW   = 23;
    localparam int WW   = 1 + EW + FW;
    localparam int MW   = FW + 1;
    localparam int PW   = 2 * MW;
    localparam int XW   = EW + 2;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam int EMAX = (1 << EW) - 1;

    typedef enum logic [1:0] {
        KIND_NUM  = 2'd0,
        KIND_ZERO = 2'd1,
        KIND_INF  = 2'd2,
        KIND_NAN  = 2'd3
    } kind_e;

    typedef struct packed {
        logic                 vld;
        kind_e                kind;
        logic                 sgn;
        logic signed [XW-1:0] exp;
        logic [MW-1:0]        ma;
        logic [MW-1:0]        mb;
    } st1_t;

    typedef struct packed {
        logic                 vld;
        kind_e                kind;
        logic                 sgn;
        logic signed [XW-1:0] exp;
        logic [PW-1:0]        prod;
    } st2_t;

    typedef struct packed {
        logic          vld;
        logic [WW-1:0] res;
        logic          ovf;
        logic          unf;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;
endpackage

// File: rtl/spm_unpack.sv
module spm_unpack
    import spm_pkg::*;
(
    input  logic [WW-1:0] op,
    output logic          sgn,
    output logic [EW-1:0] exp,
    output logic [MW-1:0] mant,
    output logic          is_zero,
    output logic          is_inf,
    output logic          is_nan
);
    logic [FW-1:0] frac;
    logic          exp_ones;

    always_comb begin
        sgn      = op[WW-1];
        exp      = op[WW-2 -: EW];
        frac     = op[FW-1:0];
        exp_ones = &exp;
        // exponent field zero: subnormal inputs are flushed to zero
        is_zero  = (exp == '0);
        is_inf   = exp_ones && (frac == '0);
        is_nan   = exp_ones && (frac != '0);
        mant     = {1'b1, frac};
    end
endmodule

// File: rtl/spm_round.sv
module spm_round
    import spm_pkg::*;
(
    input  logic [PW-1:0]        prod,
    input  logic signed [XW-1:0] exp_in,
    input  logic                 sgn,
    output logic [WW-1:0]        res,
    output logic                 ovf,
    output logic                 unf
);
    localparam logic signed [XW-1:0] EXP_MIN = XW'(1);
    localparam logic signed [XW-1:0] EXP_TOP = XW'(EMAX - 1);

    logic                 top;
    logic signed [XW-1:0] exp_n;
    logic signed [XW-1:0] exp_r;
    logic [MW-1:0]        kept;
    logic                 grd;
    logic                 rnd;
    logic                 stk;
    logic                 up;
    logic [MW:0]          msum;

    always_comb begin
        top = prod[PW-1];
        if (top) begin
            kept = prod[PW-1 -: MW];
            grd  = prod[PW-1-MW];
            rnd  = prod[PW-2-MW];
            stk  = |prod[PW-3-MW:0];
        end else begin
            kept = prod[PW-2 -: MW];
            grd  = prod[PW-2-MW];
            rnd  = prod[PW-3-MW];
            stk  = |prod[PW-4-MW:0];
        end
        exp_n = exp_in + XW'(top);
        up    = grd & (rnd | stk | kept[0]);
        msum  = {1'b0, kept} + (MW+1)'(up);
        exp_r = msum[MW] ? exp_n + EXP_MIN : exp_n;
        unf   = (exp_n < EXP_MIN);
        ovf   = !unf && (exp_r > EXP_TOP);
        if (unf) begin
            res = {sgn, {(WW-1){1'b0}}};
        end else if (ovf) begin
            res = {sgn, {EW{1'b1}}, {FW{1'b0}}};
        end else begin
            res = {sgn, exp_r[EW-1:0], msum[FW-1:0]};
        end
    end
endmodule

// File: rtl/spm_fmul_pipe.sv
module spm_fmul_pipe
    import spm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [31:0]   in_a,
    input  logic [31:0]   in_b,
    output logic          out_valid,
    output logic [31:0]   out_prod,
    output logic          out_ovf,
    output logic          out_unf
);
    localparam logic [WW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    pipe_t pipe_d, pipe_q;

    logic          sa, sb;
    logic [EW-1:0] ea, eb;
    logic [MW-1:0] ma, mb;
    logic          za, zb, ia, ib, na, nb;
    logic [WW-1:0] rnd_res;
    logic          rnd_ovf, rnd_unf;

    spm_unpack u_unpack_a (
        .op(in_a), .sgn(sa), .exp(ea), .mant(ma),
        .is_zero(za), .is_inf(ia), .is_nan(na)
    );

    spm_unpack u_unpack_b (
        .op(in_b), .sgn(sb), .exp(eb), .mant(mb),
        .is_zero(zb), .is_inf(ib), .is_nan(nb)
    );

    spm_round u_round (
        .prod(pipe_q.s2.prod), .exp_in(pipe_q.s2.exp), .sgn(pipe_q.s2.sgn),
        .res(rnd_res), .ovf(rnd_ovf), .unf(rnd_unf)
    );

    always_comb begin
        pipe_d = pipe_q;

        // stage 1: classify, sign, biased exponent sum minus one bias
        pipe_d.s1.vld = in_valid;
        pipe_d.s1.sgn = sa ^ sb;
        pipe_d.s1.exp = XW'(ea) + XW'(eb) - XW'(BIAS);
        pipe_d.s1.ma  = ma;
        pipe_d.s1.mb  = mb;
        if (na || nb || (ia && zb) || (ib && za)) begin
            pipe_d.s1.kind = KIND_NAN;
        end else if (ia || ib) begin
            pipe_d.s1.kind = KIND_INF;
        end else if (za || zb) begin
            pipe_d.s1.kind = KIND_ZERO;
        end else begin
            pipe_d.s1.kind = KIND_NUM;
        end

        // stage 2: significand product
        pipe_d.s2.vld  = pipe_q.s1.vld;
        pipe_d.s2.kind = pipe_q.s1.kind;
        pipe_d.s2.sgn  = pipe_q.s1.sgn;
        pipe_d.s2.exp  = pipe_q.s1.exp;
        pipe_d.s2.prod = PW'(pipe_q.s1.ma) * PW'(pipe_q.s1.mb);

        // stage 3: normalize, round, range check, special select
        pipe_d.s3.vld = pipe_q.s2.vld;
        pipe_d.s3.ovf = 1'b0;
        pipe_d.s3.unf = 1'b0;
        unique case (pipe_q.s2.kind)
            KIND_NUM: begin
                pipe_d.s3.res = rnd_res;
                pipe_d.s3.ovf = rnd_ovf & pipe_q.s2.vld;
                pipe_d.s3.unf = rnd_unf & pipe_q.s2.vld;
            end
            KIND_ZERO: pipe_d.s3.res = {pipe_q.s2.sgn, {(WW-1){1'b0}}};
            KIND_INF:  pipe_d.s3.res = {pipe_q.s2.sgn, {EW{1'b1}}, {FW{1'b0}}};
            default:   pipe_d.s3.res = QNAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s3.vld;
    assign out_prod  = pipe_q.s3.res;
    assign out_ovf   = pipe_q.s3.ovf;
    assign out_unf   = pipe_q.s3.unf;
endmodule

// File: rtl/spm_fmul_chk.sv
module spm_fmul_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_a,
    input logic [31:0] in_b,
    input logic        out_valid,
    input logic [31:0] out_prod,
    input logic        out_ovf,
    input logic        out_unf
);
    logic [1:0] age;
    logic       nan_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign nan_out = (out_prod[30:23] == 8'hFF) && (out_prod[22:0] != 23'd0);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && out_valid && !nan_out) |->
            (out_prod[31] == $past(in_a[31] ^ in_b[31], 3)));

    p_ovf_inf_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> (out_prod[30:0] == 31'h7F800000));

    p_unf_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> (out_prod[30:0] == 31'd0));

    p_flag_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ovf && out_unf));

    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && nan_out) |-> (out_prod == 32'h7FC00000 && !out_ovf && !out_unf));

    p_idle_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ovf && !out_unf));
endmodule

bind spm_fmul_pipe spm_fmul_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_prod(out_prod), .out_ovf(out_ovf), .out_unf(out_unf)
);

// File: tb/spm_fmul_pipe_bench.sv
`timescale 1ns/1ps
module spm_fmul_pipe_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_prod;
    logic        out_ovf;
    logic        out_unf;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [33:0] exp_q[$];
    logic [63:0] opd_q[$];
    int          due_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    spm_fmul_pipe u_spm_fmul_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_prod(out_prod), .out_ovf(out_ovf), .out_unf(out_unf)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // expected {ovf, unf, product}
    function automatic logic [33:0] model(input logic [31:0] a, input logic [31:0] b);
        logic        s, za, zb, ia, ib, na, nb, g, r, st;
        logic [47:0] p;
        logic [24:0] m;
        int          e;
        s  = a[31] ^ b[31];
        za = (a[30:23] == 8'd0);
        zb = (b[30:23] == 8'd0);
        ia = (a[30:23] == 8'hFF) && (a[22:0] == 23'd0);
        ib = (b[30:23] == 8'hFF) && (b[22:0] == 23'd0);
        na = (a[30:23] == 8'hFF) && (a[22:0] != 23'd0);
        nb = (b[30:23] == 8'hFF) && (b[22:0] != 23'd0);
        if (na || nb || (ia && zb) || (ib && za)) return {2'b00, 32'h7FC00000};
        if (ia || ib) return {2'b00, s, 8'hFF, 23'd0};
        if (za || zb) return {2'b00, s, 31'd0};
        p = {24'd0, 1'b1, a[22:0]} * {24'd0, 1'b1, b[22:0]};
        e = int'(a[30:23]) + int'(b[30:23]) - 127;
        if (p[47]) begin
            e++;
            m = {1'b0, p[47:24]}; g = p[23]; r = p[22]; st = |p[21:0];
        end else begin
            m = {1'b0, p[46:23]}; g = p[22]; r = p[21]; st = |p[20:0];
        end
        if (e < 1) return {2'b01, s, 31'd0};
        if (g && (r || st || m[0])) m = m + 25'd1;
        if (m[24]) begin
            e++;
            m = 25'h0800000;
        end
        if (e > 254) return {2'b10, s, 8'hFF, 23'd0};
        return {2'b00, s, 8'(e), m[22:0]};
    endfunction

    task automatic send(input logic [31:0] a, input logic [31:0] b, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        exp_q.push_back(model(a, b));
        opd_q.push_back({a, b});
        due_q.push_back(cyc + 3);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_a = $urandom;
            in_b = $urandom;
        end
    endtask

    // scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1: valid with nothing pending, got %h expected no output", out_prod);
                end else begin
                    logic [33:0] e;
                    logic [63:0] o;
                    int          d;
                    string       t;
                    e = exp_q.pop_front();
                    o = opd_q.pop_front();
                    d = due_q.pop_front();
                    t = tag_q.pop_front();
                    if (d != cyc) begin
                        fails++;
                        $display("FAIL R1: result arrived at cycle %0d expected %0d", cyc, d);
                    end else if ({out_ovf, out_unf, out_prod} !== e) begin
                        fails++;
                        $display("FAIL %s: %h x %h got %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                                 t, o[63:32], o[31:0], out_prod, out_ovf, out_unf,
                                 e[31:0], e[33], e[32]);
                    end
                end
            end else begin
                if (out_ovf || out_unf) begin
                    checks++;
                    fails++;
                    $display("FAIL R10: flags %b%b while idle expected 00", out_ovf, out_unf);
                end
                if (due_q.size() != 0 && due_q[0] <= cyc) begin
                    checks++;
                    fails++;
                    $display("FAIL R1: missing result at cycle %0d expected valid at %0d", cyc, due_q[0]);
                    void'(exp_q.pop_front()); void'(opd_q.pop_front());
                    void'(due_q.pop_front()); void'(tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL R1: watchdog expired, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        in_a = 32'h3F800000;
        in_b = 32'h3F800000;
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state while inputs are active
        checks++;
        if (out_valid || out_ovf || out_unf || out_prod != 32'd0) begin
            fails++;
            $display("FAIL R10: reset outputs %b %h %b%b expected 0 00000000 00",
                     out_valid, out_prod, out_ovf, out_unf);
        end
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(2);

        // directed corners
        send(32'h3F000000, 32'hBEE00000, "R2");   // 0.5 * -0.4375 = -0.21875
        send(32'h3FC00000, 32'h3FC00000, "R2");   // 1.5*1.5 needs the shift
        send(32'h3F800001, 32'h3FC00000, "R3");   // tie, odd lsb -> up
        send(32'h3F800003, 32'h3FC00000, "R3");   // tie, even lsb -> stays
        send(32'h3FFFFFFE, 32'h3F800001, "R4");   // 2^47-2 rounds across
        idle(1);
        send(32'h7F000000, 32'h40000000, "R5");
        send(32'hFF000000, 32'h40000000, "R5");
        send(32'h7F7FFFFE, 32'h3F800001, "R5");   // overflow only by the carry
        send(32'h7F7FFFFF, 32'h3F800000, "R5");   // largest finite, no flag
        send(32'h00800000, 32'h3F000000, "R6");
        send(32'h80800000, 32'h3F000000, "R6");
        send(32'h00800000, 32'h3F800000, "R6");   // smallest normal, no flag
        idle(2);
        send(32'h00400000, 32'h3F800000, "R7");
        send(32'h80000001, 32'h3F800000, "R7");
        send(32'h00000000, 32'hC0000000, "R7");
        send(32'h00000001, 32'h7F800000, "R8");   // flushed operand times infinity
        send(32'h7FC00001, 32'h3F800000, "R8");
        send(32'hFF800001, 32'h00000000, "R8");
        send(32'h7F800000, 32'h80000000, "R8");
        send(32'hFF800000, 32'h40000000, "R9");
        send(32'h7F800000, 32'hFF800000, "R9");
        idle(3);

        // random stream
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b;
            logic [33:0] m;
            string       t;
            a = $urandom;
            b = $urandom;
            if ($urandom_range(3) != 0) begin
                a[30:23] = 8'(64 + $urandom_range(127));
                b[30:23] = 8'(64 + $urandom_range(127));
            end
            m = model(a, b);
            t = m[33] ? "R5" : m[32] ? "R6" : "R2";
            send(a, b, t);
            if ($urandom_range(7) == 0) idle(1 + $urandom_range(2));
        end
        idle(6);
        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1: %0d results never arrived expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule